// File: doc/BRIEF.md
# Host Port Address Window Decoder

This block sits behind the host-side bus front end of a peripheral controller. For every host access it reports whether the access lands inside the address window of one of the configured peripheral ports, which port that is, and the byte offset of the access inside that window. Bus framing, the data path and interrupt logic are handled elsewhere. The block only decides where an access belongs.

Each port carries a base address, a mode, an address-space bit, a mailbox size code and a split flag. The mode sets how large the window is and how the base is aligned. A single-byte I/O port compares 16 address bits. A single-byte memory port compares all 32 bits. An endpoint decodes 8 bytes and an index/data pair decodes 4 bytes. A mailbox decodes 2^n bytes, and twice that when its two directions are split. A port reserved for out-of-band, bus-master or flash traffic never claims an address.

The result is registered, so it appears one clock after the access is presented.

Top module: `host_window_decode`

## Requirements
- R1: While rst_n is low and on the first cycle after reset, hit, hit_port and hit_offset are all 0.
- R2: The result for an access presented with acc_valid=1 appears on the outputs after the next rising clock edge. A cycle with acc_valid=0 gives hit=0 on the following cycle.
- R3: Mode code 1 (I/O byte) hits only on I/O cycles (acc_mem=0) where acc_addr[15:0] equals base[15:0]. The upper address bits are ignored and the offset is 0.
- R4: Mode code 2 (memory byte) hits only on memory cycles (acc_mem=1) where all 32 address bits equal the base. The offset is 0.
- R5: Mode code 3 (endpoint) decodes an 8-byte window at the base with the low 3 bits cleared. The offset is acc_addr[2:0].
- R6: Mode code 4 (index/data) decodes a 4-byte window at the base with the low 2 bits cleared. The offset is acc_addr[1:0].
- R7: Mode code 5 (mailbox) decodes a window of 2^L bytes, where L is the port's 3-bit size code. The window is 2^(L+1) bytes when the port's split flag is 1. The offset is the access address minus the aligned base.
- R8: A mailbox, endpoint or index/data base that is not aligned to its window is masked down to the alignment and is not rejected.
- R9: Mode codes 0 (off), 6 (out-of-band/bus-master/flash) and 7 (reserved) never produce a hit.
- R10: When several ports match, the port with the lowest index is reported.
- R11: For modes 3, 4 and 5 the port's space bit selects the cycle type: 1 means memory cycles with a 32-bit compare, and 0 means I/O cycles with only the low 16 bits compared.
- R12: When there is no hit, hit_port and hit_offset are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_mem | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| acc_addr | input | ADDR_W | Access address |
| cfg_base | input | NUM_PORTS*ADDR_W | Per-port base; port i at [i*ADDR_W +: ADDR_W] |
| cfg_mode | input | NUM_PORTS*3 | Per-port mode code (0..7) |
| cfg_mem | input | NUM_PORTS | Per-port space bit for modes 3..5 |
| cfg_mbx_lg | input | NUM_PORTS*MBX_LG_W | Per-port mailbox size code L |
| cfg_split | input | NUM_PORTS | Per-port mailbox split flag |
| hit | output | 1 | Registered: the access matched a port |
| hit_port | output | $clog2(NUM_PORTS) | Registered index of the winning port |
| hit_offset | output | 2^MBX_LG_W | Registered byte offset within the window |

## Verification
Two functions can act on the same access: the window match of several ports and the lowest-index priority choice. The random stimulus places all bases in a small shared region so that windows overlap often. It also mixes I/O and memory cycles so that space filtering and priority meet in the same cycle. Directed cases overlap port 0 and port 1 on purpose and then disable port 0. Each result is compared with a bench model that scans the ports from the highest index down, so the lowest match is the one that remains.

// File: rtl/hwd_pkg.sv
package hwd_pkg;
    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        MODE_OFF      = 3'd0,
        MODE_IO_BYTE  = 3'd1,
        MODE_MEM_BYTE = 3'd2,
        MODE_ENDPOINT = 3'd3,
        MODE_INDEX    = 3'd4,
        MODE_MAILBOX  = 3'd5,
        MODE_STREAM   = 3'd6,
        MODE_RSVD     = 3'd7
    } port_mode_e;
endpackage

// File: rtl/hwd_port_match.sv
module hwd_port_match
    import hwd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IO_W   = 16,
    parameter int LG_W   = 3,
    parameter int OFF_W  = 8
) (
    input  logic              acc_mem,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [ADDR_W-1:0] base,
    input  port_mode_e        mode,
    input  logic              mem_space,
    input  logic [LG_W-1:0]   mbx_lg,
    input  logic              split,
    output logic              hit,
    output logic [OFF_W-1:0]  offset
);
    logic [LG_W:0]     win_lg;
    logic              eligible;
    logic              space_ok;
    logic [ADDR_W-1:0] low_mask;
    logic [ADDR_W-1:0] io_keep;

    always_comb begin
        win_lg   = '0;
        eligible = 1'b0;
        space_ok = 1'b0;
        case (mode)
            MODE_IO_BYTE: begin
                eligible = 1'b1;
                space_ok = !acc_mem;
            end
            MODE_MEM_BYTE: begin
                eligible = 1'b1;
                space_ok = acc_mem;
            end
            MODE_ENDPOINT: begin
                eligible = 1'b1;
                win_lg   = (LG_W+1)'(3);
                space_ok = (acc_mem == mem_space);
            end
            MODE_INDEX: begin
                eligible = 1'b1;
                win_lg   = (LG_W+1)'(2);
                space_ok = (acc_mem == mem_space);
            end
            MODE_MAILBOX: begin
                eligible = 1'b1;
                win_lg   = {1'b0, mbx_lg} + {{LG_W{1'b0}}, split};
                space_ok = (acc_mem == mem_space);
            end
            default: begin
                eligible = 1'b0;
            end
        endcase
        low_mask = ~({ADDR_W{1'b1}} << win_lg);
        io_keep  = acc_mem ? {ADDR_W{1'b1}}
                           : {{(ADDR_W-IO_W){1'b0}}, {IO_W{1'b1}}};
        hit      = eligible && space_ok
                   && (((acc_addr ^ base) & ~low_mask & io_keep) == '0);
        offset   = OFF_W'(acc_addr & low_mask);
    end

    // Reserved traffic classes and disabled ports must stay silent (R9)
    always_comb begin
        if (mode == MODE_STREAM || mode == MODE_OFF || mode == MODE_RSVD) begin
            assert_no_reserved_hit_R9: assert (!hit);
        end
    end
endmodule

// File: rtl/hwd_low_pick.sv
module hwd_low_pick #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

    // Winner must request and no lower index may request (R10)
    always_comb begin
        if (any) begin
            assert_pick_lowest_R10: assert (req[idx]
                && ((req & ((N'(1) << idx) - N'(1))) == '0));
        end
    end
endmodule

// File: rtl/host_window_decode.sv
module host_window_decode
    import hwd_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int ADDR_W    = 32,
    parameter int IO_W      = 16,
    parameter int MBX_LG_W  = 3,
    localparam int PORT_W   = $clog2(NUM_PORTS),
    localparam int OFF_W    = 1 << MBX_LG_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          acc_valid,
    input  logic                          acc_mem,
    input  logic [ADDR_W-1:0]             acc_addr,
    input  logic [NUM_PORTS*ADDR_W-1:0]   cfg_base,
    input  logic [NUM_PORTS*MODE_W-1:0]   cfg_mode,
    input  logic [NUM_PORTS-1:0]          cfg_mem,
    input  logic [NUM_PORTS*MBX_LG_W-1:0] cfg_mbx_lg,
    input  logic [NUM_PORTS-1:0]          cfg_split,
    output logic                          hit,
    output logic [PORT_W-1:0]             hit_port,
    output logic [OFF_W-1:0]              hit_offset
);
    typedef struct packed {
        logic              hit;
        logic [PORT_W-1:0] port;
        logic [OFF_W-1:0]  off;
    } result_t;

    result_t              res_d, res_q;
    logic [NUM_PORTS-1:0] req_vec;
    logic [OFF_W-1:0]     off_arr [NUM_PORTS];
    logic                 req_any;
    logic [PORT_W-1:0]    win_idx;

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
        hwd_port_match #(
            .ADDR_W (ADDR_W),
            .IO_W   (IO_W),
            .LG_W   (MBX_LG_W),
            .OFF_W  (OFF_W)
        ) u_match (
            .acc_mem   (acc_mem),
            .acc_addr  (acc_addr),
            .base      (cfg_base[g*ADDR_W +: ADDR_W]),
            .mode      (port_mode_e'(cfg_mode[g*MODE_W +: MODE_W])),
            .mem_space (cfg_mem[g]),
            .mbx_lg    (cfg_mbx_lg[g*MBX_LG_W +: MBX_LG_W]),
            .split     (cfg_split[g]),
            .hit       (req_vec[g]),
            .offset    (off_arr[g])
        );
    end

    hwd_low_pick #(
        .N     (NUM_PORTS),
        .IDX_W (PORT_W)
    ) u_pick (
        .req (req_vec),
        .any (req_any),
        .idx (win_idx)
    );

    always_comb begin
        res_d = '0;
        if (acc_valid && req_any) begin
            res_d.hit  = 1'b1;
            res_d.port = win_idx;
            res_d.off  = off_arr[win_idx];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign hit        = res_q.hit;
    assign hit_port   = res_q.port;
    assign hit_offset = res_q.off;

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !hit);

    assert_port0_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && req_vec[0]) |=> (hit && hit_port == '0));

    assert_miss_clean_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (hit_port == '0 && hit_offset == '0));
endmodule

// File: tb/sim_host_window_decode.sv
module sim_host_window_decode;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 4;
    localparam int AW = 32;
    localparam int LW = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            acc_valid = 1'b0;
    logic            acc_mem = 1'b0;
    logic [AW-1:0]   acc_addr = '0;
    logic [NP*AW-1:0] cfg_base = '0;
    logic [NP*3-1:0] cfg_mode = '0;
    logic [NP-1:0]   cfg_mem = '0;
    logic [NP*LW-1:0] cfg_mbx_lg = '0;
    logic [NP-1:0]   cfg_split = '0;
    logic            hit;
    logic [1:0]      hit_port;
    logic [7:0]      hit_offset;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    host_window_decode u0 (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_mem(acc_mem),
        .acc_addr(acc_addr), .cfg_base(cfg_base), .cfg_mode(cfg_mode),
        .cfg_mem(cfg_mem), .cfg_mbx_lg(cfg_mbx_lg), .cfg_split(cfg_split),
        .hit(hit), .hit_port(hit_port), .hit_offset(hit_offset)
    );

    task automatic set_port(input int i, input logic [31:0] b, input logic [2:0] m,
                            input logic sp, input logic [2:0] lg, input logic spl);
        cfg_base[i*AW +: AW] = b;
        cfg_mode[i*3 +: 3]   = m;
        cfg_mem[i]           = sp;
        cfg_mbx_lg[i*LW +: LW] = lg;
        cfg_split[i]         = spl;
    endtask

    task automatic compare(input string tag, input logic eh, input logic [1:0] ep,
                           input logic [7:0] eo);
        checks++;
        if (hit !== eh || hit_port !== ep || hit_offset !== eo) begin
            errors++;
            $display("FAIL %s: got hit=%0b port=%0d off=%0d, expected hit=%0b port=%0d off=%0d",
                     tag, hit, hit_port, hit_offset, eh, ep, eo);
        end
    endtask

    // Drive at a falling edge; the result is visible one rising edge later.
    task automatic access(input logic m, input logic [31:0] a, input string tag,
                          input logic eh, input logic [1:0] ep, input logic [7:0] eo);
        acc_valid = 1'b1;
        acc_mem   = m;
        acc_addr  = a;
        @(negedge clk);
        compare(tag, eh, ep, eo);
    endtask

    // Range-based reference: aligned base, size, and inclusive lower / exclusive upper bound.
    function automatic void model(input logic m, input logic [31:0] a, output logic eh,
                                  output logic [1:0] ep, output logic [7:0] eo);
        eh = 1'b0; ep = '0; eo = '0;
        for (int i = NP - 1; i >= 0; i--) begin
            logic [2:0] md = cfg_mode[i*3 +: 3];
            longint size = 0;
            bit     want_mem = 1'b0;
            longint av, bv, al;
            case (md)
                3'd1: begin size = 1; want_mem = 1'b0; end
                3'd2: begin size = 1; want_mem = 1'b1; end
                3'd3: begin size = 8; want_mem = cfg_mem[i]; end
                3'd4: begin size = 4; want_mem = cfg_mem[i]; end
                3'd5: begin
                    size = longint'(1) << (cfg_mbx_lg[i*LW +: LW] + cfg_split[i]);
                    want_mem = cfg_mem[i];
                end
                default: size = 0;
            endcase
            if (size != 0 && want_mem == m) begin
                av = m ? longint'(a) : longint'(a[15:0]);
                bv = m ? longint'(cfg_base[i*AW +: AW]) : longint'(cfg_base[i*AW +: 16]);
                al = bv - (bv % size);
                if (av >= al && av < al + size) begin
                    eh = 1'b1;
                    ep = 2'(i);
                    eo = 8'(av - al);
                end
            end
        end
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic eh;
        logic [1:0] ep;
        logic [7:0] eo;
        int unsigned seed_ret;
        seed_ret = $urandom(32'd4242);
        repeat (3) @(negedge clk);
        compare("R1 during reset", 1'b0, 2'd0, 8'd0);
        acc_valid = 1'b1; acc_mem = 1'b1; acc_addr = 32'h0;
        set_port(0, 32'h0, 3'd2, 1'b1, 3'd0, 1'b0);
        @(negedge clk);
        compare("R1 held in reset with live match", 1'b0, 2'd0, 8'd0);
        acc_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1 first cycle after reset", 1'b0, 2'd0, 8'd0);

        // I/O byte port
        set_port(0, 32'h0000_0060, 3'd1, 1'b0, 3'd0, 1'b0);
        access(1'b0, 32'h1234_0060, "R3 io hit upper bits ignored", 1'b1, 2'd0, 8'd0);
        access(1'b1, 32'h0000_0060, "R3 memory cycle ignored", 1'b0, 2'd0, 8'd0);
        access(1'b0, 32'h0000_0061, "R3 io neighbour misses", 1'b0, 2'd0, 8'd0);
        acc_valid = 1'b0;
        @(negedge clk);
        compare("R2 idle cycle after hit", 1'b0, 2'd0, 8'd0);

        // Memory byte port
        set_port(0, 32'h0, 3'd0, 1'b0, 3'd0, 1'b0);
        set_port(1, 32'hFEDC_0010, 3'd2, 1'b0, 3'd0, 1'b0);
        access(1'b1, 32'hFEDC_0010, "R4 memory byte hit", 1'b1, 2'd1, 8'd0);
        access(1'b1, 32'hFEDC_0011, "R4 memory neighbour misses", 1'b0, 2'd0, 8'd0);
        access(1'b1, 32'h7EDC_0010, "R4 upper bit differs", 1'b0, 2'd0, 8'd0);

        // Endpoint
        set_port(2, 32'h1000_0008, 3'd3, 1'b1, 3'd0, 1'b0);
        access(1'b1, 32'h1000_000F, "R5 endpoint last byte", 1'b1, 2'd2, 8'd7);
        access(1'b1, 32'h1000_0010, "R5 endpoint past end", 1'b0, 2'd0, 8'd0);
        set_port(2, 32'h1000_000D, 3'd3, 1'b1, 3'd0, 1'b0);
        access(1'b1, 32'h1000_0009, "R8 endpoint base masked", 1'b1, 2'd2, 8'd1);
        access(1'b0, 32'h0000_0009, "R11 endpoint memory space ignores io", 1'b0, 2'd0, 8'd0);

        // Index/data in I/O space
        set_port(2, 32'h0000_0CF8, 3'd4, 1'b0, 3'd0, 1'b0);
        access(1'b0, 32'hABCD_0CFB, "R6 R11 index/data io offset 3", 1'b1, 2'd2, 8'd3);
        access(1'b0, 32'h0000_0CFC, "R6 index/data past end", 1'b0, 2'd0, 8'd0);
        access(1'b1, 32'h0000_0CF8, "R11 io-space port ignores memory", 1'b0, 2'd0, 8'd0);

        // Mailbox
        set_port(3, 32'h0000_2000, 3'd5, 1'b1, 3'd4, 1'b0);
        access(1'b1, 32'h0000_200F, "R7 mailbox single last byte", 1'b1, 2'd3, 8'd15);
        access(1'b1, 32'h0000_2010, "R7 mailbox single past end", 1'b0, 2'd0, 8'd0);
        set_port(3, 32'h0000_2000, 3'd5, 1'b1, 3'd4, 1'b1);
        access(1'b1, 32'h0000_201F, "R7 mailbox split doubles", 1'b1, 2'd3, 8'd31);
        set_port(3, 32'h0000_2013, 3'd5, 1'b1, 3'd4, 1'b0);
        access(1'b1, 32'h0000_2010, "R8 mailbox base masked down", 1'b1, 2'd3, 8'd0);
        set_port(3, 32'h0000_2000, 3'd5, 1'b1, 3'd7, 1'b1);
        access(1'b1, 32'h0000_20FF, "R7 largest mailbox offset", 1'b1, 2'd3, 8'd255);

        // Reserved classes
        set_port(3, 32'h0000_2000, 3'd6, 1'b1, 3'd4, 1'b0);
        access(1'b1, 32'h0000_2000, "R9 stream port never hits", 1'b0, 2'd0, 8'd0);
        set_port(3, 32'h0000_2000, 3'd7, 1'b1, 3'd4, 1'b0);
        access(1'b1, 32'h0000_2000, "R9 reserved mode never hits", 1'b0, 2'd0, 8'd0);
        set_port(3, 32'h0000_2000, 3'd0, 1'b1, 3'd4, 1'b0);
        access(1'b1, 32'h0000_2000, "R9 R12 off port never hits", 1'b0, 2'd0, 8'd0);

        // Priority
        set_port(0, 32'h0000_3000, 3'd5, 1'b1, 3'd5, 1'b0);
        set_port(1, 32'h0000_3004, 3'd4, 1'b1, 3'd0, 1'b0);
        access(1'b1, 32'h0000_3006, "R10 overlap lowest index wins", 1'b1, 2'd0, 8'd6);
        set_port(0, 32'h0000_3000, 3'd6, 1'b1, 3'd5, 1'b0);
        access(1'b1, 32'h0000_3006, "R10 next port after disable", 1'b1, 2'd1, 8'd2);

        // Random overlap mix
        for (int n = 0; n < 3000; n++) begin
            if (n % 40 == 0) begin
                for (int p = 0; p < NP; p++) begin
                    set_port(p, $urandom & 32'h0000_00FF, 3'($urandom), 1'($urandom),
                             3'($urandom % 6), 1'($urandom));
                end
            end
            acc_mem  = 1'($urandom);
            acc_addr = $urandom & 32'h0000_01FF;
            if ($urandom % 4 == 0) acc_addr[31:16] = 16'($urandom);
            acc_valid = ($urandom % 8) != 0;
            if (acc_valid) model(acc_mem, acc_addr, eh, ep, eo);
            else begin eh = 1'b0; ep = '0; eo = '0; end
            @(negedge clk);
            compare("random R2 R3 R4 R5 R6 R7 R8 R10 R11 R12", eh, ep, eo);
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule